// File: doc/BRIEF.md
# Atomic Set/Clear/Toggle GPIO Port

This block is one general-purpose I/O port behind a simple register bus. Each pin has an output latch and a direction bit. Software changes pins by writing masks to separate set, clear and toggle registers, so a single write alters exactly the selected pins and needs no read-modify-write. A combined register carries a set mask and a clear mask in one write; where the two overlap, clear takes priority. Pin levels come back through a two-flop synchronizer and are read from a data register.

A strap input is sampled while reset is held. It fixes how a six-pin group leaves reset. With the strap high, the FSM enters `ST_LOCKED`: the group is plain GPIO, and writes to the alternate-select register are dropped. With the strap low, the FSM enters `ST_RELEASED`: the group starts on its alternate function, and software may hand any of its pins back to GPIO. The FSM has no transitions once reset ends. Only reset can move it, by sampling the strap again. The port exports a per-pin mux select for the alternate function. While a pin is selected for its alternate function, its GPIO output enable is forced off.

Register map (3-bit address): 0 DATA (read: synchronized pin levels), 1 DIR (read/write), 2 ALTSEL (read/write, group bits only), 3 LATCH (read: output latch), 4 TOGGLE, 5 SET, 6 CLEAR, 7 SETCLR (write only; set mask in wdata[15:0], clear mask in wdata[31:16]).

Top module: `gpio_port`

## Requirements
- R1: Reset clears every output latch and every direction bit, so pin_out and pin_oe are 0 after reset.
- R2: A write to address 5 (SET) drives pin_out high for each bit that is 1 in wdata[15:0]. Bits written as 0 leave their pins unchanged.
- R3: A write to address 6 (CLEAR) drives pin_out low for each bit that is 1 in wdata[15:0]. Bits written as 0 leave their pins unchanged.
- R4: A write to address 4 (TOGGLE) inverts pin_out for each bit that is 1 in wdata[15:0]. Bits written as 0 leave their pins unchanged.
- R5: A write to address 7 (SETCLR) sets the pins in wdata[15:0] and clears the pins in wdata[31:16] in the same cycle. Where both bits are 1, the pin goes low.
- R6: Address 1 (DIR) is read/write, and a 1 selects output. pin_oe equals DIR with the alternate-selected pins masked off.
- R7: A read of address 0 returns pin_in passed through two flops. A pin_in change that is present before clock edge k shows up in rdata after edge k+1, and not after edge k.
- R8: If the strap was high during reset, alt_sel stays 0, address 2 reads 0, and writes to address 2 are ignored.
- R9: If the strap was low during reset, alt_sel starts at 0x03F0 (pins 4 to 9). Writes to address 2 then set alt_sel to wdata[9:4] at those positions, and bits outside the group are ignored.
- R10: Writes to address 0 (DATA) and address 3 (LATCH) change nothing. Address 3 reads back the output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_strap | input | 1 | Strap that fixes the mode of the pin group, sampled during reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 32 | Write data; the upper half is used only by SETCLR |
| rdata | output | 32 | Read data for addr (combinational) |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output latch values |
| pin_oe | output | 16 | Per-pin output enable |
| alt_sel | output | 16 | Per-pin alternate-function mux select |

## Verification
Setting a pin and clearing it can happen in the same cycle. Only a SETCLR write produces this, so the bench provokes it with overlapping masks, both in directed cases and in random writes. The result is judged per bit: overlapping bits must be low, bits only in the set mask must be high, and all other bits must keep their earlier value. A second clash arises when the strap locked the group. An ALTSEL write then arrives in the same cycle as a check of the lock, and the bench judges it by seeing alt_sel and the ALTSEL read stay at 0.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    typedef enum logic [2:0] {
        RA_DATA   = 3'd0,
        RA_DIR    = 3'd1,
        RA_ALT    = 3'd2,
        RA_LATCH  = 3'd3,
        RA_TGL    = 3'd4,
        RA_SET    = 3'd5,
        RA_CLR    = 3'd6,
        RA_SETCLR = 3'd7
    } reg_addr_e;

    typedef enum logic {
        ST_RELEASED = 1'b0,
        ST_LOCKED   = 1'b1
    } strap_state_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tgl_en,
    input  logic [W-1:0] tgl_mask,
    input  logic         set_en,
    input  logic [W-1:0] set_mask,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    // Clear is applied last, so it overrides a set on the same pin.
    always_comb begin
        nxt = q;
        if (tgl_en) nxt = nxt ^ tgl_mask;
        if (set_en) nxt = nxt | set_mask;
        if (clr_en) nxt = nxt & ~clr_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/gpio_strap_ctl.sv
module gpio_strap_ctl
    import gpio_port_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strap,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] alt,
    output logic         locked
);
    strap_state_e state, state_nxt;

    always_comb begin
        unique case (state)
            ST_LOCKED:   state_nxt = ST_LOCKED;
            ST_RELEASED: state_nxt = ST_RELEASED;
            default:     state_nxt = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= strap ? ST_LOCKED : ST_RELEASED;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alt <= strap ? '0 : '1;
        end else begin
            unique case (state)
                ST_LOCKED:   alt <= '0;
                ST_RELEASED: if (wr_en) alt <= wdata;
                default:     alt <= '0;
            endcase
        end
    end

    always_comb locked = (state == ST_LOCKED);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS   = 16,
    parameter int GRP_LSB = 4,
    parameter int GRP_W   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 grp_strap,
    input  logic                 wr_en,
    input  logic [2:0]           addr,
    input  logic [2*NPINS-1:0]   wdata,
    output logic [2*NPINS-1:0]   rdata,
    input  logic [NPINS-1:0]     pin_in,
    output logic [NPINS-1:0]     pin_out,
    output logic [NPINS-1:0]     pin_oe,
    output logic [NPINS-1:0]     alt_sel
);
    localparam int DW  = 2 * NPINS;
    localparam int PAD = NPINS - GRP_W;

    reg_addr_e           ra;
    logic [NPINS-1:0]    dir_q;
    logic [NPINS-1:0]    pin_sync;
    logic [GRP_W-1:0]    grp_alt;
    logic                strap_locked;
    logic                wr_dir, wr_alt, wr_tgl, wr_set, wr_clr;
    logic [NPINS-1:0]    clr_mask;

    assign ra     = reg_addr_e'(addr);
    assign wr_dir = wr_en && (ra == RA_DIR);
    assign wr_alt = wr_en && (ra == RA_ALT);
    assign wr_tgl = wr_en && (ra == RA_TGL);
    assign wr_set = wr_en && (ra == RA_SET || ra == RA_SETCLR);
    assign wr_clr = wr_en && (ra == RA_CLR || ra == RA_SETCLR);
    assign clr_mask = (ra == RA_SETCLR) ? wdata[DW-1:NPINS] : wdata[NPINS-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata[NPINS-1:0];
    end

    gpio_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_out_latch #(.W(NPINS)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgl_en   (wr_tgl),
        .tgl_mask (wdata[NPINS-1:0]),
        .set_en   (wr_set),
        .set_mask (wdata[NPINS-1:0]),
        .clr_en   (wr_clr),
        .clr_mask (clr_mask),
        .q        (pin_out)
    );

    gpio_strap_ctl #(.W(GRP_W)) u_strap (
        .clk    (clk),
        .rst_n  (rst_n),
        .strap  (grp_strap),
        .wr_en  (wr_alt),
        .wdata  (wdata[GRP_LSB +: GRP_W]),
        .alt    (grp_alt),
        .locked (strap_locked)
    );

    assign alt_sel = {{PAD{1'b0}}, grp_alt} << GRP_LSB;
    assign pin_oe  = dir_q & ~alt_sel;

    always_comb begin
        rdata = '0;
        unique case (ra)
            RA_DATA:  rdata[NPINS-1:0] = pin_sync;
            RA_DIR:   rdata[NPINS-1:0] = dir_q;
            RA_ALT:   rdata[NPINS-1:0] = alt_sel;
            RA_LATCH: rdata[NPINS-1:0] = pin_out;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int N = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [2:0]     addr,
    input logic [2*N-1:0] wdata,
    input logic [N-1:0]   pin_out,
    input logic [N-1:0]   pin_oe,
    input logic [N-1:0]   alt_sel,
    input logic           locked
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && pin_oe == '0));

    a_r2_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_SET) |=>
            ((pin_out & $past(wdata[N-1:0])) == $past(wdata[N-1:0])));

    a_r3_clear_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_CLR) |=> ((pin_out & $past(wdata[N-1:0])) == '0));

    a_r4_toggle_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_TGL) |=> (pin_out == ($past(pin_out) ^ $past(wdata[N-1:0]))));

    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_SETCLR) |=> ((pin_out & $past(wdata[2*N-1:N])) == '0));

    a_r8_locked_no_alt: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (alt_sel == '0));
endmodule

bind gpio_port gpio_port_chk #(.N(NPINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .alt_sel (alt_sel),
    .locked  (strap_locked)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    localparam int N = 16;
    localparam logic [15:0] GMASK = 16'h03F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        grp_strap = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, alt_sel;

    int checks = 0;
    int errors = 0;
    logic [15:0] e_latch, e_dir, e_alt;
    logic        e_locked;

    always #5 clk = ~clk;

    gpio_port u_dut (
        .clk (clk), .rst_n (rst_n), .grp_strap (grp_strap),
        .wr_en (wr_en), .addr (addr), .wdata (wdata), .rdata (rdata),
        .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe), .alt_sel (alt_sel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model_wr(input logic [2:0] a, input logic [31:0] d);
        case (a)
            3'd1: e_dir = d[15:0];
            3'd2: if (!e_locked) e_alt = d[15:0] & GMASK;
            3'd4: e_latch = e_latch ^ d[15:0];
            3'd5: e_latch = e_latch | d[15:0];
            3'd6: e_latch = e_latch & ~d[15:0];
            3'd7: e_latch = (e_latch | d[15:0]) & ~d[31:16];
            default: ;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd1: return "R6";
            3'd2: return "R8/R9";
            3'd4: return "R4";
            3'd5: return "R2";
            3'd6: return "R3";
            3'd7: return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        grp_strap = s; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e_latch = '0; e_dir = '0; e_locked = s;
        e_alt = s ? 16'h0 : GMASK;
    endtask

    task automatic chk_outs(input string tag);
        chk({tag, " pin_out"}, {16'h0, pin_out}, {16'h0, e_latch});
        chk({tag, " pin_oe"},  {16'h0, pin_oe},  {16'h0, e_dir & ~e_alt});
        chk({tag, " alt_sel"}, {16'h0, alt_sel}, {16'h0, e_alt});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // Locked strap
        do_reset(1'b1);
        @(negedge clk);
        chk("R1 pin_out after reset", {16'h0, pin_out}, 32'h0);
        chk("R1 pin_oe after reset", {16'h0, pin_oe}, 32'h0);
        rd_chk(3'd1, 32'h0, "R1 DIR after reset");

        bus_wr(3'd5, 32'h0000_0005);
        rd_chk(3'd3, 32'h0005, "R2 set bits 0,2");
        bus_wr(3'd5, 32'h0000_0000);
        rd_chk(3'd3, 32'h0005, "R2 zero mask no effect");
        bus_wr(3'd4, 32'h0000_0101);
        rd_chk(3'd3, 32'h0104, "R4 toggle");
        bus_wr(3'd6, 32'h0000_0104);
        rd_chk(3'd3, 32'h0000, "R3 clear");
        bus_wr(3'd5, 32'h0000_F00F);
        bus_wr(3'd7, 32'h0F0F_00FF);
        rd_chk(3'd3, {16'h0, e_latch}, "R5 clear wins on overlap");
        chk("R5 overlap value", {16'h0, e_latch}, 32'h0000_F0F0);
        bus_wr(3'd0, 32'h0000_FFFF);
        bus_wr(3'd3, 32'h0000_FFFF);
        rd_chk(3'd3, 32'h0000_F0F0, "R10 writes to DATA/LATCH ignored");
        bus_wr(3'd1, 32'h0000_00FF);
        rd_chk(3'd1, 32'h0000_00FF, "R6 DIR readback");
        chk("R6 pin_oe", {16'h0, pin_oe}, 32'h0000_00FF);

        bus_wr(3'd2, 32'h0000_03F0);
        chk("R8 alt_sel locked", {16'h0, alt_sel}, 32'h0);
        rd_chk(3'd2, 32'h0, "R8 ALTSEL reads 0");

        // Synchronizer latency
        @(negedge clk);
        pin_in = 16'hA55A; addr = 3'd0;
        @(negedge clk);
        rd_chk(3'd0, 32'h0, "R7 not visible after one edge");
        @(negedge clk);
        rd_chk(3'd0, 32'h0000_A55A, "R7 visible after two edges");

        for (int i = 0; i < 150; i++) begin
            logic [2:0]  a;
            logic [31:0] d;
            a = 3'($urandom_range(0, 7));
            d = $urandom();
            if (i % 5 == 0) d[31:16] = d[15:0] | d[31:16];
            bus_wr(a, d);
            chk_outs(tag_of(a));
        end

        // Released strap
        do_reset(1'b0);
        @(negedge clk);
        chk("R9 alt_sel after reset", {16'h0, alt_sel}, 32'h0000_03F0);
        rd_chk(3'd2, 32'h0000_03F0, "R9 ALTSEL read");
        bus_wr(3'd1, 32'h0000_FFFF);
        chk("R6 pin_oe masked by alt", {16'h0, pin_oe}, 32'h0000_FC0F);
        bus_wr(3'd2, 32'h0000_F05F);
        chk("R9 alt write group only", {16'h0, alt_sel}, 32'h0000_0050);
        rd_chk(3'd2, 32'h0000_0050, "R9 ALTSEL readback");

        for (int i = 0; i < 150; i++) begin
            logic [2:0]  a;
            logic [31:0] d;
            a = 3'($urandom_range(0, 7));
            d = $urandom();
            bus_wr(a, d);
            chk_outs(tag_of(a));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule